// File: doc/BRIEF.md
# Sign-Magnitude Variable-Length Register ALU

This block performs one register-to-register operation per accepted request on operands kept in sign-magnitude form, where every operand carries its own magnitude, a bit length and a separate sign bit. Negative numbers are never held in two's complement. The operations cover signed addition and subtraction, signed greater-than and equality comparison, and the bitwise not, or and and operations. Arithmetic results shrink or grow their length to fit the magnitude. The bitwise operations pad the shorter operand on the left, with zeros for or and with ones for and.

A request is presented with `in_valid` high for one clock. The result value, length and sign, the overflow flag and the persistent condition flag appear on the outputs one clock later, qualified by `out_valid`. The largest magnitude width is set by the parameter `W`. Lengths are `$clog2(W+1)` bits wide.

Top module: `smvl_alu`

## Requirements
- R1: Opcode `in_op` uses these encodings: 0 add, 1 subtract (first minus second), 2 greater-than, 3 equal, 4 not, 5 or, 6 and. Operands are sign-magnitude values. Magnitude bits at or above an operand's length are ignored.
- R2: After add or subtract without overflow, `out_len` equals the position of the leftmost 1 bit of the result magnitude, counting the least significant bit as position 1. A zero magnitude gives length 0.
- R3: An add or subtract whose result magnitude is zero always gives `out_sign` = 0, including the case -N + N.
- R4: If an add or subtract magnitude reaches 2^W, `out_ovf` is 1, `out_val` holds the low W bits and `out_len` is W. Every other result has `out_ovf` = 0.
- R5: Greater-than sets `out_cond` to 1 when the signed first operand exceeds the signed second, and sets it to 0 otherwise. A zero with either sign counts as zero.
- R6: Equal sets `out_cond` to 1 when the signed values match, and to 0 otherwise. +0 and -0 are equal.
- R7: Only the compare opcodes change `out_cond`; it holds its value across all other operations. A compare returns the first operand unchanged: its magnitude masked to its length, its length, and its sign.
- R8: Not inverts every bit of the first operand within its length. It keeps that length and the first operand's sign.
- R9: Or pads the shorter operand on the left with 0s. The result length is the larger of the two lengths and the result sign is the first operand's sign.
- R10: And pads the shorter operand on the left with 1s, using the same length rule and sign rule as or.
- R11: Results appear exactly one clock after the accepted request, with `out_valid` high for one cycle. Synchronous reset clears `out_valid`, `out_cond` and `out_ovf`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code |
| in_a_val | input | W | First operand magnitude (also the destination) |
| in_a_len | input | LW | First operand length |
| in_a_sign | input | 1 | First operand sign, 1 for negative |
| in_b_val | input | W | Second operand magnitude |
| in_b_len | input | LW | Second operand length |
| in_b_sign | input | 1 | Second operand sign |
| out_valid | output | 1 | Result strobe |
| out_val | output | W | Result magnitude |
| out_len | output | LW | Result length |
| out_sign | output | 1 | Result sign |
| out_cond | output | 1 | Condition flag from the last compare |
| out_ovf | output | 1 | Arithmetic overflow |

## Verification
The bench targets mixed-sign sums where the smaller magnitude must be taken from the larger one. A design that added raw magnitudes there would return a large, wrong value. It checks -5 + 5 and 5 - 5, where a slip leaves a negative zero, and it feeds operands with junk above their length, which a design that did not mask would leak into the result. It compares +0 with -0 and pairs of negatives, where a raw magnitude compare inverts the answer. It also runs the or and and cases with each operand longer in turn, which catch a wrong pad bit or a result length kept from the destination. Sums that reach 2^W must raise overflow, and the condition flag is checked after bitwise operations to catch a flag that gets rewritten.

// File: rtl/smvl_pkg.sv
package smvl_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_GT  = 3'd2,
        OP_EQ  = 3'd3,
        OP_NOT = 3'd4,
        OP_OR  = 3'd5,
        OP_AND = 3'd6
    } alu_op_e;

    typedef enum logic [1:0] {
        GRP_ARITH,
        GRP_CMP,
        GRP_LOGIC,
        GRP_NONE
    } op_group_e;

    function automatic op_group_e group_of(input alu_op_e op);
        case (op)
            OP_ADD, OP_SUB:        return GRP_ARITH;
            OP_GT, OP_EQ:          return GRP_CMP;
            OP_NOT, OP_OR, OP_AND: return GRP_LOGIC;
            default:               return GRP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/smvl_arith.sv
module smvl_arith #(
    parameter  int W  = 16,
    localparam int LW = $clog2(W + 1)
) (
    input  logic [W-1:0]  a_mag,
    input  logic          a_sign,
    input  logic [W-1:0]  b_mag,
    input  logic          b_sign,
    input  logic          negate_b,
    output logic [W-1:0]  r_mag,
    output logic [LW-1:0] r_len,
    output logic          r_sign,
    output logic          r_ovf
);

    function automatic logic [LW-1:0] lead_pos(input logic [W-1:0] v);
        logic [LW-1:0] p;
        p = '0;
        for (int i = 0; i < W; i++) begin
            if (v[i]) p = LW'(i + 1);
        end
        return p;
    endfunction

    logic [W:0] wide;
    logic       eff_b_sign;
    logic       raw_sign;

    always_comb begin
        eff_b_sign = b_sign ^ negate_b;
        raw_sign   = a_sign;
        if (a_sign == eff_b_sign) begin
            wide = {1'b0, a_mag} + {1'b0, b_mag};
        end else if (a_mag >= b_mag) begin
            wide = {1'b0, a_mag - b_mag};
        end else begin
            wide     = {1'b0, b_mag - a_mag};
            raw_sign = eff_b_sign;
        end
        r_ovf  = wide[W];
        r_mag  = wide[W-1:0];
        r_sign = raw_sign && (wide != '0);
        r_len  = wide[W] ? LW'(W) : lead_pos(wide[W-1:0]);
    end

endmodule

// File: rtl/smvl_cmp.sv
module smvl_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_mag,
    input  logic         a_sign,
    input  logic [W-1:0] b_mag,
    input  logic         b_sign,
    output logic         gt,
    output logic         eq
);

    logic a_neg;
    logic b_neg;

    always_comb begin
        a_neg = a_sign && (a_mag != '0);
        b_neg = b_sign && (b_mag != '0);
        eq    = (a_mag == b_mag) && (a_neg == b_neg);
        if (a_neg != b_neg) gt = b_neg;
        else if (a_neg)     gt = a_mag < b_mag;
        else                gt = a_mag > b_mag;
    end

endmodule

// File: rtl/smvl_logic.sv
module smvl_logic #(
    parameter  int W  = 16,
    localparam int LW = $clog2(W + 1)
) (
    input  smvl_pkg::alu_op_e op,
    input  logic [W-1:0]      a_mag,
    input  logic [LW-1:0]     a_len,
    input  logic [W-1:0]      b_mag,
    input  logic [LW-1:0]     b_len,
    output logic [W-1:0]      r_mag,
    output logic [LW-1:0]     r_len
);
    import smvl_pkg::*;

    logic [W-1:0] a_keep;
    logic [W-1:0] b_keep;
    logic [W-1:0] r_keep;

    for (genvar g = 0; g < W; g++) begin : g_bit
        assign a_keep[g] = LW'(g) < a_len;
        assign b_keep[g] = LW'(g) < b_len;
        assign r_keep[g] = a_keep[g] | b_keep[g];
    end

    always_comb begin
        r_len = (b_len > a_len) ? b_len : a_len;
        case (op)
            OP_NOT: begin
                r_mag = ~a_mag & a_keep;
                r_len = a_len;
            end
            OP_OR:   r_mag = (a_mag | b_mag) & r_keep;
            OP_AND:  r_mag = (a_mag | ~a_keep) & (b_mag | ~b_keep) & r_keep;
            default: r_mag = '0;
        endcase
    end

endmodule

// File: rtl/smvl_alu.sv
module smvl_alu #(
    parameter  int W  = 16,
    localparam int LW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [2:0]    in_op,
    input  logic [W-1:0]  in_a_val,
    input  logic [LW-1:0] in_a_len,
    input  logic          in_a_sign,
    input  logic [W-1:0]  in_b_val,
    input  logic [LW-1:0] in_b_len,
    input  logic          in_b_sign,
    output logic          out_valid,
    output logic [W-1:0]  out_val,
    output logic [LW-1:0] out_len,
    output logic          out_sign,
    output logic          out_cond,
    output logic          out_ovf
);
    import smvl_pkg::*;

    alu_op_e      op;
    logic [W-1:0] a_m;
    logic [W-1:0] b_m;

    assign op = alu_op_e'(in_op);

    for (genvar g = 0; g < W; g++) begin : g_mask
        assign a_m[g] = in_a_val[g] && (LW'(g) < in_a_len);
        assign b_m[g] = in_b_val[g] && (LW'(g) < in_b_len);
    end

    logic [W-1:0]  ar_mag;
    logic [LW-1:0] ar_len;
    logic          ar_sign;
    logic          ar_ovf;
    logic          c_gt;
    logic          c_eq;
    logic [W-1:0]  lg_mag;
    logic [LW-1:0] lg_len;

    smvl_arith #(.W(W)) u_arith (
        .a_mag(a_m), .a_sign(in_a_sign), .b_mag(b_m), .b_sign(in_b_sign),
        .negate_b(op == OP_SUB),
        .r_mag(ar_mag), .r_len(ar_len), .r_sign(ar_sign), .r_ovf(ar_ovf)
    );

    smvl_cmp #(.W(W)) u_cmp (
        .a_mag(a_m), .a_sign(in_a_sign), .b_mag(b_m), .b_sign(in_b_sign),
        .gt(c_gt), .eq(c_eq)
    );

    smvl_logic #(.W(W)) u_logic (
        .op(op), .a_mag(a_m), .a_len(in_a_len), .b_mag(b_m), .b_len(in_b_len),
        .r_mag(lg_mag), .r_len(lg_len)
    );

    alu_op_e out_op;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_val   <= '0;
            out_len   <= '0;
            out_sign  <= 1'b0;
            out_cond  <= 1'b0;
            out_ovf   <= 1'b0;
            out_op    <= OP_ADD;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_op  <= op;
                out_ovf <= 1'b0;
                case (group_of(op))
                    GRP_ARITH: begin
                        out_val  <= ar_mag;
                        out_len  <= ar_len;
                        out_sign <= ar_sign;
                        out_ovf  <= ar_ovf;
                    end
                    GRP_LOGIC: begin
                        out_val  <= lg_mag;
                        out_len  <= lg_len;
                        out_sign <= in_a_sign;
                    end
                    default: begin
                        out_val  <= a_m;
                        out_len  <= in_a_len;
                        out_sign <= in_a_sign;
                        if (op == OP_GT) out_cond <= c_gt;
                        if (op == OP_EQ) out_cond <= c_eq;
                    end
                endcase
            end
        end
    end

    // R3: arithmetic zero never negative
    a_r3_zero_positive: assert property (@(posedge clk) disable iff (rst)
        out_valid && group_of(out_op) == GRP_ARITH && out_val == '0 && !out_ovf |-> !out_sign);

    // R2: length matches leading one of magnitude
    a_r2_len_fits: assert property (@(posedge clk) disable iff (rst)
        out_valid && group_of(out_op) == GRP_ARITH && !out_ovf |->
        ((out_len == '0) ? (out_val == '0) : (out_val[out_len-1] && (out_val >> out_len) == '0)));

    // R4: overflow only from arithmetic
    a_r4_ovf_arith_only: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ovf |-> group_of(out_op) == GRP_ARITH);

    // R7: condition flag stable without a compare
    a_r7_cond_hold: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && group_of(op) == GRP_CMP) |=> $stable(out_cond));

    // R8: not keeps the destination length
    a_r8_not_len: assert property (@(posedge clk) disable iff (rst)
        in_valid && op == OP_NOT |=> out_len == $past(in_a_len));

    // R9 / R10: or and and grow to the longer operand
    a_r9_pad_len: assert property (@(posedge clk) disable iff (rst)
        in_valid && (op == OP_OR || op == OP_AND) |=>
        out_len >= $past(in_a_len) && out_len >= $past(in_b_len));

    // R11: one result per accepted request, one cycle later
    a_r11_latency: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

endmodule

// File: tb/test_smvl_alu.sv
module test_smvl_alu;
    localparam int W  = 16;
    localparam int LW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [2:0]    in_op = '0;
    logic [W-1:0]  in_a_val = '0;
    logic [LW-1:0] in_a_len = '0;
    logic          in_a_sign = 1'b0;
    logic [W-1:0]  in_b_val = '0;
    logic [LW-1:0] in_b_len = '0;
    logic          in_b_sign = 1'b0;
    logic          out_valid;
    logic [W-1:0]  out_val;
    logic [LW-1:0] out_len;
    logic          out_sign;
    logic          out_cond;
    logic          out_ovf;

    always #5 clk = ~clk;

    smvl_alu #(.W(W)) i_smvl_alu (.*);

    typedef struct {
        string         tag;
        logic [W-1:0]  val;
        logic [LW-1:0] len;
        logic          sign;
        logic          cond;
        logic          ovf;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    logic model_cond = 1'b0;

    function automatic int bitlen(input longint m);
        int p = 0;
        for (int i = 0; i < 40; i++) if (m[i]) p = i + 1;
        return p;
    endfunction

    function automatic longint lmask(input int len);
        return (longint'(1) << len) - 1;
    endfunction

    task automatic drive(input string tag, input int op,
                         input longint av, input int al, input bit as_,
                         input longint bv, input int bl, input bit bs_);
        exp_t   e;
        longint am, bm, sa, sb, r, mag;
        int     lmax;
        am = av & lmask(al);
        bm = bv & lmask(bl);
        sa = as_ ? -am : am;
        sb = bs_ ? -bm : bm;
        lmax = (al > bl) ? al : bl;
        e.tag = tag; e.ovf = 1'b0; e.cond = model_cond;
        e.val = W'(am); e.len = LW'(al); e.sign = as_;
        case (op)
            0, 1: begin
                r   = (op == 0) ? sa + sb : sa - sb;
                mag = (r < 0) ? -r : r;
                e.ovf  = mag >= (longint'(1) << W);
                e.val  = W'(mag);
                e.len  = e.ovf ? LW'(W) : LW'(bitlen(mag));
                e.sign = r < 0;
            end
            2: begin model_cond = sa > sb;  e.cond = model_cond; end
            3: begin model_cond = sa == sb; e.cond = model_cond; end
            4: e.val = W'(~am & lmask(al));
            5: begin e.val = W'((am | bm) & lmask(lmax)); e.len = LW'(lmax); end
            6: begin
                e.val = W'((am | ~lmask(al)) & (bm | ~lmask(bl)) & lmask(lmax));
                e.len = LW'(lmax);
            end
            default: ;
        endcase
        exp_q.push_back(e);
        @(negedge clk);
        in_valid = 1'b1; in_op = 3'(op);
        in_a_val = W'(av); in_a_len = LW'(al); in_a_sign = as_;
        in_b_val = W'(bv); in_b_len = LW'(bl); in_b_sign = bs_;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor: pops expected items as results appear
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R11: unexpected out_valid, actual 1 expected 0");
                end else begin
                    e = exp_q.pop_front();
                    if (out_val !== e.val || out_len !== e.len || out_sign !== e.sign ||
                        out_cond !== e.cond || out_ovf !== e.ovf) begin
                        n_fail++;
                        $display("FAIL %s: actual val=%h len=%0d sign=%b cond=%b ovf=%b expected val=%h len=%0d sign=%b cond=%b ovf=%b",
                                 e.tag, out_val, out_len, out_sign, out_cond, out_ovf,
                                 e.val, e.len, e.sign, e.cond, e.ovf);
                    end
                end
            end
        end
    end

    initial begin
        repeat (2000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_cond !== 1'b0 || out_ovf !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 reset: actual valid=%b cond=%b ovf=%b expected 0 0 0",
                     out_valid, out_cond, out_ovf);
        end
        // R1 R2: arithmetic with junk above the lengths
        drive("R1 add 5+3",        0, 'hF005, 4, 0, 'h0003, 2, 0);
        drive("R1 add -5+3",       0, 5, 3, 1, 3, 2, 0);
        drive("R2 sub 3-(-4)",     1, 3, 2, 0, 4, 3, 1);
        drive("R2 add 9+(-2) len", 0, 9, 4, 0, 2, 2, 1);
        drive("R3 add -5+5 zero",  0, 5, 3, 1, 5, 3, 0);
        drive("R3 sub 5-5 zero",   1, 5, 3, 0, 5, 3, 0);
        drive("R4 ovf FFFF+1",     0, 'hFFFF, 16, 0, 1, 1, 0);
        drive("R4 ovf -FFFF-1",    1, 'hFFFF, 16, 1, 1, 1, 0);
        // R5 R6: compares
        drive("R5 gt -3>-5",       2, 3, 2, 1, 5, 3, 1);
        drive("R7 cond after add", 0, 1, 1, 0, 1, 1, 0);
        drive("R5 gt +0>-0",       2, 0, 0, 0, 0, 0, 1);
        drive("R5 gt 2>-7",        2, 2, 2, 0, 7, 3, 1);
        drive("R5 gt -2>1",        2, 2, 2, 1, 1, 1, 0);
        drive("R6 eq +0==-0",      3, 0, 4, 0, 0, 4, 1);
        drive("R8 not keeps len",  4, 'hFF05, 4, 1, 0, 0, 0);
        drive("R7 cond after not", 4, 0, 3, 0, 0, 0, 0);
        drive("R6 eq 5==-5",       3, 5, 3, 0, 5, 3, 1);
        drive("R9 or b longer",    5, 1, 1, 0, 4, 3, 0);
        drive("R9 or a longer",    5, 'h11, 5, 1, 'hF2, 2, 0);
        drive("R10 and b longer",  6, 2, 2, 0, 6, 4, 0);
        drive("R10 and a longer",  6, 'hB, 4, 1, 1, 2, 0);
        drive("R7 cond after and", 6, 0, 0, 0, 0, 0, 0);
        drive("R6 eq -7==-7",      3, 7, 3, 1, 7, 3, 1);
        repeat (3) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R11: actual %0d results missing expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule